// File: doc/BRIEF.md
# Supervised Tamper Loop Monitor

This block watches a resistively supervised tamper loop and a shock sensor. The loop voltage arrives as a 10-bit converter code. Every code is sorted into one of three bands: loop broken, loop shorted, or loop healthy. The shock sensor arrives as a level input. A millisecond strobe (`ms_tick`) paces all timing, so every window and blink period is counted in ticks rather than in clock cycles.

An abnormal reading is not trusted at once. It becomes a confirmed tamper event only if the same abnormal cause holds continuously for a short verification window. Shorter spikes are discarded. A change of cause during the window restarts it.

A confirmed event latches the alarm and asserts an actuator-inhibit output. It also blinks an LED at 2 Hz with the default parameters (250-tick half period at a 1 kHz tick). It freezes a 2-bit cause code and captures the value of a free-running tick counter as a timestamp. The latch is released only by a manual clear, and only once the loop and the shock sensor are quiet again.

The controller has three named states:
- `ST_ARMED`: no abnormal input.
- `ST_VERIFY`: an abnormal cause is being timed.
- `ST_LATCHED`: the alarm is held.

Its transitions are:
- `ARMED→VERIFY`: a cause appears.
- `VERIFY→ARMED`: the cause vanishes.
- `VERIFY→VERIFY`: the cause changes, which restarts the window.
- `VERIFY→LATCHED`: the window completes.
- `LATCHED→ARMED`: a manual clear arrives while the inputs are quiet.

Top module: `tamper_loop_monitor`

## Requirements
- R1: After reset, `alarm`, `inhibit` and `led` are 0, `cause` is 00 and `stamp` is 0.
- R2: The loop code is decoded into three bands. A code ≥ OPEN_MIN (921) is a broken loop, cause 01. A code ≤ SHORT_MAX (102) is a shorted loop, cause 10. Codes 103..920 are healthy and never start an event.
- R3: `shock_in`=1 is abnormal with cause 11. It takes priority over the loop band when both are abnormal.
- R4: An event is confirmed on the VERIFY_TICKS-th tick seen while one abnormal cause has held without a break. If the inputs return to healthy earlier, the window is dropped. If the cause changes earlier, the window restarts at zero.
- R5: Once confirmed, `alarm` and `inhibit` stay at 1 whatever the inputs do, until a clear is accepted (R9).
- R6: While latched, `led` is 1 from the first latched cycle and toggles after every BLINK_TICKS ticks. While not latched, `led` is 0.
- R7: On confirmation, `stamp` takes the value the free-running tick counter held at that edge. It is unchanged at every other time.
- R8: While latched, `cause` holds the confirmed cause unchanged. Outside the latch it reads 00.
- R9: `manual_clr` releases the latch only when no abnormal cause is present. In that case the block returns to ARMED with `cause` 00. Otherwise `manual_clr` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle timing strobe (1 ms nominal) |
| loop_code | input | ADC_W (10) | Converter code of the supervised loop |
| shock_in | input | 1 | Shock sensor level, 1 = shock |
| manual_clr | input | 1 | Manual clear request for the latch |
| alarm | output | 1 | Latched tamper alarm |
| inhibit | output | 1 | Actuator inhibit, asserted while latched |
| led | output | 1 | Alarm LED blink output |
| cause | output | 2 | 00 none, 01 open, 10 short, 11 shock |
| stamp | output | TICK_W (24) | Tick count captured at confirmation |

## Verification
The bound checker checks on every cycle that the latch never drops unless an accepted clear is present. It also checks that the latch never drops while an abnormal input is present, and that the cause and the timestamp stay frozen outside a confirmation edge. Two more per-cycle checks are that the LED is dark outside the latch and that a shock confirmation reports cause 11. The exact length of the verification window, the restart on a cause change, the blink period and the captured timestamp value need the bench. Its per-cycle reference model compares all outputs under:
- spikes shorter than the window,
- alternating causes,
- codes at the band edges (102/103, 920/921),
- clear attempts during active tampering.

// File: rtl/tamper_pkg.sv
package tamper_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_OPEN  = 2'b01,
        CAUSE_SHORT = 2'b10,
        CAUSE_SHOCK = 2'b11
    } cause_t;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'b00,
        ST_VERIFY  = 2'b01,
        ST_LATCHED = 2'b10
    } mon_state_t;

endpackage

// File: rtl/tamper_band_decode.sv
module tamper_band_decode
    import tamper_pkg::*;
#(
    parameter int ADC_W     = 10,
    parameter int OPEN_MIN  = 921,
    parameter int SHORT_MAX = 102
) (
    input  logic [ADC_W-1:0] code,
    input  logic             shock,
    output cause_t           cand
);

    localparam logic [ADC_W-1:0] OPEN_LIM  = ADC_W'(OPEN_MIN);
    localparam logic [ADC_W-1:0] SHORT_LIM = ADC_W'(SHORT_MAX);

    logic is_open;
    logic is_short;

    assign is_open  = (code >= OPEN_LIM);
    assign is_short = (code <= SHORT_LIM);

    // shock has priority over the loop band
    always_comb begin
        if (shock)         cand = CAUSE_SHOCK;
        else if (is_open)  cand = CAUSE_OPEN;
        else if (is_short) cand = CAUSE_SHORT;
        else               cand = CAUSE_NONE;
    end

endmodule

// File: rtl/tamper_persist.sv
module tamper_persist #(
    parameter int LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic done
);

    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign done = !clear && tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == LAST) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tamper_blinker.sv
module tamper_blinker #(
    parameter int HALF_TICKS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic led
);

    localparam int CW = (HALF_TICKS < 2) ? 1 : $clog2(HALF_TICKS);
    localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

    logic [CW-1:0] cnt;
    logic          phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b1;
        end else if (!run) begin
            cnt   <= '0;
            phase <= 1'b1;
        end else if (tick) begin
            if (cnt == LAST) begin
                cnt   <= '0;
                phase <= ~phase;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign led = run && phase;

endmodule

// File: rtl/tamper_loop_monitor.sv
module tamper_loop_monitor
    import tamper_pkg::*;
#(
    parameter int ADC_W        = 10,
    parameter int OPEN_MIN     = 921,
    parameter int SHORT_MAX    = 102,
    parameter int VERIFY_TICKS = 20,
    parameter int BLINK_TICKS  = 250,
    parameter int TICK_W       = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic [ADC_W-1:0]  loop_code,
    input  logic              shock_in,
    input  logic              manual_clr,
    output logic              alarm,
    output logic              inhibit,
    output logic              led,
    output logic [1:0]        cause,
    output logic [TICK_W-1:0] stamp
);

    mon_state_t        state_q, state_d;
    cause_t            cand;
    cause_t            held_q;
    cause_t            cause_q;
    logic [TICK_W-1:0] tick_cnt;
    logic [TICK_W-1:0] stamp_q;
    logic              win_clear;
    logic              win_done;
    logic              in_latch;

    tamper_band_decode #(
        .ADC_W    (ADC_W),
        .OPEN_MIN (OPEN_MIN),
        .SHORT_MAX(SHORT_MAX)
    ) u_band (
        .code (loop_code),
        .shock(shock_in),
        .cand (cand)
    );

    assign win_clear = (state_q != ST_VERIFY) || (cand != held_q);

    tamper_persist #(
        .LIMIT(VERIFY_TICKS)
    ) u_window (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(win_clear),
        .tick (ms_tick),
        .done (win_done)
    );

    assign in_latch = (state_q == ST_LATCHED);

    tamper_blinker #(
        .HALF_TICKS(BLINK_TICKS)
    ) u_blink (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (in_latch),
        .tick (ms_tick),
        .led  (led)
    );

    // free-running tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tick_cnt <= '0;
        else if (ms_tick) tick_cnt <= tick_cnt + 1'b1;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: begin
                if (cand != CAUSE_NONE) state_d = ST_VERIFY;          // ARMED->VERIFY
            end
            ST_VERIFY: begin
                if (cand == CAUSE_NONE) state_d = ST_ARMED;           // VERIFY->ARMED
                else if (win_done)      state_d = ST_LATCHED;         // VERIFY->LATCHED
            end
            ST_LATCHED: begin
                if (manual_clr && cand == CAUSE_NONE) state_d = ST_ARMED; // LATCHED->ARMED
            end
            default: state_d = ST_ARMED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    // registered outputs: held cause, reported cause, timestamp
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q  <= CAUSE_NONE;
            cause_q <= CAUSE_NONE;
            stamp_q <= '0;
        end else begin
            unique case (state_q)
                ST_ARMED: begin
                    held_q <= cand;
                end
                ST_VERIFY: begin
                    if (cand != held_q) begin
                        held_q <= cand;                               // VERIFY->VERIFY restart
                    end else if (win_done) begin
                        cause_q <= held_q;
                        stamp_q <= tick_cnt;
                    end
                end
                ST_LATCHED: begin
                    if (manual_clr && cand == CAUSE_NONE) cause_q <= CAUSE_NONE;
                end
                default: begin
                    held_q  <= CAUSE_NONE;
                    cause_q <= CAUSE_NONE;
                end
            endcase
        end
    end

    assign alarm   = in_latch;
    assign inhibit = in_latch;
    assign cause   = cause_q;
    assign stamp   = stamp_q;

endmodule

// File: rtl/tamper_loop_monitor_chk.sv
module tamper_loop_monitor_chk #(
    parameter int ADC_W     = 10,
    parameter int OPEN_MIN  = 921,
    parameter int SHORT_MAX = 102,
    parameter int TICK_W    = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADC_W-1:0]  loop_code,
    input logic              shock_in,
    input logic              manual_clr,
    input logic              alarm,
    input logic              inhibit,
    input logic              led,
    input logic [1:0]        cause,
    input logic [TICK_W-1:0] stamp
);

    logic abnormal;
    assign abnormal = shock_in || (loop_code >= ADC_W'(OPEN_MIN)) || (loop_code <= ADC_W'(SHORT_MAX));

    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && !manual_clr) |=> (alarm && inhibit));

    // R9
    clr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && abnormal) |=> alarm);

    // R8
    cause_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && $past(alarm)) |-> $stable(cause));

    // R8
    cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm |-> (cause == 2'b00));

    // R6
    led_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm |-> !led);

    // R7
    stamp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(alarm) |-> $stable(stamp));

    // R4
    confirm_abn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> $past(abnormal));

    // R3
    shock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(alarm) && $past(shock_in)) |-> (cause == 2'b11));

endmodule

bind tamper_loop_monitor tamper_loop_monitor_chk #(
    .ADC_W    (ADC_W),
    .OPEN_MIN (OPEN_MIN),
    .SHORT_MAX(SHORT_MAX),
    .TICK_W   (TICK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .loop_code (loop_code),
    .shock_in  (shock_in),
    .manual_clr(manual_clr),
    .alarm     (alarm),
    .inhibit   (inhibit),
    .led       (led),
    .cause     (cause),
    .stamp     (stamp)
);

// File: tb/tamper_loop_monitor_tb.sv
module tamper_loop_monitor_tb;

    localparam int V  = 4;
    localparam int B  = 3;
    localparam int TW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ms_tick = 1'b0;
    logic [9:0]    loop_code = 10'd500;
    logic          shock_in = 1'b0;
    logic          manual_clr = 1'b0;
    logic          alarm, inhibit, led;
    logic [1:0]    cause;
    logic [TW-1:0] stamp;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    tamper_loop_monitor #(
        .VERIFY_TICKS(V),
        .BLINK_TICKS (B),
        .TICK_W      (TW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .loop_code(loop_code),
        .shock_in(shock_in), .manual_clr(manual_clr), .alarm(alarm),
        .inhibit(inhibit), .led(led), .cause(cause), .stamp(stamp)
    );

    always #4 clk = ~clk;

    // reference model (state 0 armed, 1 verify, 2 latched)
    int m_state = 0, m_held = 0, m_cnt = 0, m_bcnt = 0, m_phase = 1;
    int m_cause = 0, m_stamp = 0, m_tick = 0;

    function automatic int classify(int code, bit shk);
        if (shk)         return 3;
        if (code >= 921) return 1;
        if (code <= 102) return 2;
        return 0;
    endfunction

    always @(posedge clk) begin
        int c;
        int old_tick;
        if (!rst_n) begin
            m_state = 0; m_held = 0; m_cnt = 0; m_bcnt = 0; m_phase = 1;
            m_cause = 0; m_stamp = 0; m_tick = 0;
        end else begin
            c = classify(int'(loop_code), shock_in);
            old_tick = m_tick;
            if (m_state != 2) begin
                m_phase = 1; m_bcnt = 0;
            end else if (ms_tick) begin
                if (m_bcnt == B - 1) begin m_bcnt = 0; m_phase = 1 - m_phase; end
                else m_bcnt++;
            end
            case (m_state)
                0: if (c != 0) begin m_state = 1; m_held = c; m_cnt = 0; end
                1: begin
                    if (c == 0) begin m_state = 0; m_cnt = 0; end
                    else if (c != m_held) begin m_held = c; m_cnt = 0; end
                    else if (ms_tick) begin
                        if (m_cnt == V - 1) begin
                            m_state = 2; m_cause = m_held; m_stamp = old_tick; m_cnt = 0;
                        end else m_cnt++;
                    end
                end
                default: if (manual_clr && c == 0) begin m_state = 0; m_cause = 0; end
            endcase
            if (ms_tick) m_tick = old_tick + 1;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cyc++;
        ms_tick <= (cyc % 5 == 4);
        if (rst_n) begin
            check(alarm   == (m_state == 2), "R5 alarm",   int'(alarm),   int'(m_state == 2));
            check(inhibit == (m_state == 2), "R5 inhibit", int'(inhibit), int'(m_state == 2));
            check(led == ((m_state == 2) && m_phase == 1), "R6 led", int'(led),
                  int'((m_state == 2) && m_phase == 1));
            check(int'(cause) == m_cause, "R8 cause", int'(cause), m_cause);
            check(int'(stamp) == m_stamp, "R7 stamp", int'(stamp), m_stamp);
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(int code, bit shk);
        loop_code = 10'(code);
        shock_in  = shk;
    endtask

    task automatic do_clear();
        manual_clr = 1'b1;
        wait_cyc(1);
        manual_clr = 1'b0;
        wait_cyc(2);
    endtask

    initial begin
        wait_cyc(3);
        // R1 reset values
        check(alarm == 0 && inhibit == 0 && led == 0, "R1 flags", int'({alarm, inhibit, led}), 0);
        check(cause == 0 && stamp == 0, "R1 cause/stamp", int'(cause), 0);
        rst_n = 1'b1;

        // R2 healthy codes, including band edges, never latch
        drive(500, 0); wait_cyc(40);
        drive(920, 0); wait_cyc(40);
        check(alarm == 0, "R2 code 920 healthy", int'(alarm), 0);
        drive(103, 0); wait_cyc(40);
        check(alarm == 0, "R2 code 103 healthy", int'(alarm), 0);

        // R4 short spike rejected
        drive(1000, 0); wait_cyc(10);
        drive(500, 0);  wait_cyc(20);
        check(alarm == 0, "R4 spike rejected", int'(alarm), 0);

        // R4 alternating causes restart the window
        for (int i = 0; i < 6; i++) begin
            drive((i % 2 == 0) ? 1000 : 50, 0);
            wait_cyc(15);
        end
        check(alarm == 0, "R4 cause change restarts", int'(alarm), 0);
        drive(500, 0); wait_cyc(10);

        // R2 open at edge 921
        drive(921, 0); wait_cyc(40);
        check(alarm == 1 && cause == 2'b01, "R2 open latched", int'(cause), 1);
        // R5 latch holds after input recovers; R6 blinking checked per cycle
        drive(500, 0); wait_cyc(60);
        check(alarm == 1, "R5 latch held", int'(alarm), 1);
        // R9 clear ignored while abnormal
        drive(30, 0); do_clear();
        check(alarm == 1 && cause == 2'b01, "R9 clear ignored", int'(alarm), 1);
        drive(500, 0); do_clear();
        check(alarm == 0 && cause == 2'b00, "R9 clear accepted", int'(alarm), 0);

        // R2 short at edge 102
        drive(102, 0); wait_cyc(40);
        check(alarm == 1 && cause == 2'b10, "R2 short latched", int'(cause), 2);
        drive(500, 0); do_clear();

        // R3 shock with open loop: shock wins
        drive(1000, 1); wait_cyc(40);
        check(alarm == 1 && cause == 2'b11, "R3 shock priority", int'(cause), 3);
        // R8 cause frozen when the input changes to open
        drive(1000, 0); wait_cyc(30);
        check(cause == 2'b11, "R8 cause frozen", int'(cause), 3);
        drive(500, 0); do_clear();
        // R7 stamp kept after clear
        check(int'(stamp) == m_stamp && stamp != 0, "R7 stamp kept", int'(stamp), m_stamp);
        wait_cyc(20);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule